// File: doc/BRIEF.md
# Byte-Level EEPROM Write and Protection Controller

This block models the command side of a 256-byte serial EEPROM once the two-wire bus has already been turned into byte events. A bus front end tells it when a device select arrives, which command class that select carries, and whether the read bit is set. It also passes on each byte the master writes, each byte the master wants to read, and the stop condition. For every select and every written byte the block answers with an acknowledge decision. For every read request it returns the data byte. While the self-timed internal write runs, it raises a busy flag.

Writes are first gathered in a 16-byte page buffer and committed at stop. The commit starts an internal write cycle whose length is a parameter counted in clocks. During that cycle the device answers no select at all, so the master can poll for completion. The lower half of the array (00h to 7Fh) can be locked in two ways: by a reversible protection flag, which set and clear commands control, or by a permanent lock that nothing can undo. All three protection commands use the framing of a byte write, and their address and data bytes are ignored. A select of a protection command class with the read bit set works as a status query and opens no transaction. No input has back-pressure: each event pulse is taken in the cycle it is high. If several are high together, stop wins over select, select over a written byte, and a written byte over a read request. Every response appears as a one-cycle valid pulse on the next clock.

Top module: `wpc_eeprom_ctrl`

## Requirements
- R1: After reset, busy, rsp_valid and rd_valid are low, both protections are off, the address counter is 00h and every array byte reads FFh.
- R2: A select with sel_kind=00 (memory) and sel_rd=0 is acknowledged. The first byte after it loads the address counter and each later byte is a data byte. Both are acknowledged when the address is writable. At stop, buffered data is committed and busy is high for exactly WRITE_CYCLES cycles, starting the cycle after stop.
- R3: Data bytes increment only the low 4 address bits, so a page write wraps within its 16-byte page. A byte that lands again on a column already written in the same transaction replaces the earlier one.
- R4: While busy is high, every select is answered with no-acknowledge, whatever its class or read bit.
- R5: A select with sel_kind=00 and sel_rd=1 is acknowledged and reads from the current address counter. Each rd_req returns the byte there and then advances the full 8-bit counter, which wraps from FFh to 00h. A random read is an address byte followed by a new read select.
- R6: sel_kind=01 (set-protect) turns on reversible protection. Once any protection is on, a data byte aimed at 00h–7Fh gets no-acknowledge and the stop that follows starts no write cycle. Addresses 80h–FFh stay writable. A set-protect is refused on its data byte if protection is already on.
- R7: sel_kind=10 (clear-protect) turns reversible protection off when the permanent lock is not set, after which the lower half can be written again.
- R8: sel_kind=11 (permanent-protect) sets a lock that nothing clears. Afterwards, clear-protect and permanent-protect get no-acknowledge on their data byte and start no write cycle, and the lower half cannot be written.
- R9: A protection-class select with sel_rd=1 answers no-acknowledge if the queried protection is set and acknowledge if it is not. Classes 01 and 10 query the reversible flag and class 11 queries the permanent lock.
- R10: Reads return the stored data whatever the protection state.
- R11: rsp_valid pulses exactly one cycle after each accepted select or written byte. rd_valid pulses one cycle after an rd_req that falls inside an open read transaction, and stays low for any other rd_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_valid | input | 1 | Device select event |
| sel_kind | input | 2 | Command class: 00 memory, 01 set-protect, 10 clear-protect, 11 permanent-protect |
| sel_rd | input | 1 | Read bit of the select |
| wr_valid | input | 1 | Byte written by the master |
| wr_byte | input | 8 | Value of the written byte |
| rd_req | input | 1 | Master requests one read byte |
| stop | input | 1 | Stop condition; closes the transaction |
| rsp_valid | output | 1 | Acknowledge decision is valid |
| rsp_ack | output | 1 | 1 = acknowledge, 0 = no-acknowledge |
| rd_valid | output | 1 | Read byte is valid |
| rd_data | output | 8 | Read byte |
| busy | output | 1 | Internal write cycle running |

## Verification
The write path is driven with a single byte, a page write that crosses the end of its page, a 17-byte burst that returns to its first column, and writes aimed below and above 80h under each protection state. These patterns separate column wrap from full-address increment, and protected from unprotected halves. Reads cover random access, continuation across a page edge and rollover past FFh, which shows that the read counter is 8 bits wide while the write counter wraps at 4 bits. The protection sequence runs set, redundant set, clear, permanent and clear-after-permanent, with status queries in between, so each transition is seen both at the data-byte acknowledge and as the presence or absence of a busy pulse.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

  typedef enum logic [1:0] {
    K_MEM  = 2'b00,
    K_SETP = 2'b01,
    K_CLRP = 2'b10,
    K_PERM = 2'b11
  } cmd_kind_t;

  typedef enum logic [2:0] {
    TX_NONE,
    TX_WADDR,
    TX_WDATA,
    TX_PADDR,
    TX_PDATA,
    TX_READ,
    TX_DEAD
  } tx_state_t;

endpackage

// File: rtl/wpc_cycle_timer.sv
module wpc_cycle_timer #(
  parameter int CYCLES = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (start)
      cnt_q <= CNT_W'(CYCLES);
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

  // R2
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(CYCLES));

endmodule

// File: rtl/wpc_page_buf.sv
module wpc_page_buf #(
  parameter int PAGE_BYTES = 16,
  parameter int DATA_W     = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         we,
  input  logic [$clog2(PAGE_BYTES)-1:0] col,
  input  logic [DATA_W-1:0]            din,
  output logic [PAGE_BYTES-1:0]        mask,
  output logic [PAGE_BYTES*DATA_W-1:0] data_flat
);
  localparam int COL_W = $clog2(PAGE_BYTES);

  logic [DATA_W-1:0] lane_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) lane_q[i] <= '0;
    end else if (clr) begin
      mask_q <= '0;
    end else if (we) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (col == COL_W'(i)) begin
          mask_q[i] <= 1'b1;
          lane_q[i] <= din;
        end
      end
    end
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_flat
    assign data_flat[g*DATA_W +: DATA_W] = lane_q[g];
  end

  assign mask = mask_q;

  // R3
  lane_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !clr) |=> (mask != '0));

endmodule

// File: rtl/wpc_array.sv
module wpc_array #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              commit,
  input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] page,
  input  logic [PAGE_BYTES-1:0]             mask,
  input  logic [PAGE_BYTES*DATA_W-1:0]      data_flat,
  input  logic [ADDR_W-1:0]                 rd_addr,
  output logic [DATA_W-1:0]                 rd_data
);
  localparam int COL_W = $clog2(PAGE_BYTES);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (commit) begin
      for (int c = 0; c < PAGE_BYTES; c++) begin
        if (mask[c]) mem_q[{page, COL_W'(c)}] <= data_flat[c*DATA_W +: DATA_W];
      end
    end
  end

  assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/wpc_eeprom_ctrl.sv
module wpc_eeprom_ctrl
  import wpc_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 8,
  parameter int PAGE_BYTES   = 16,
  parameter int WRITE_CYCLES = 20000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_valid,
  input  logic [1:0]        sel_kind,
  input  logic              sel_rd,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              rd_req,
  input  logic              stop,
  output logic              rsp_valid,
  output logic              rsp_ack,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy
);
  localparam int COL_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - COL_W;

  tx_state_t         tx_q;
  cmd_kind_t         pkind_q;
  logic [ADDR_W-1:0] addr_q;
  logic              soft_q, perm_q, pend_q;
  logic [DATA_W-1:0] arr_rd;
  logic [PAGE_BYTES-1:0]        buf_mask;
  logic [PAGE_BYTES*DATA_W-1:0] buf_data;

  logic go_stop, go_sel, go_wr, go_rd;
  logic prot_on, lower_hit, prot_ok, buf_we, buf_clr, commit, start;
  cmd_kind_t sel_k;

  assign sel_k   = cmd_kind_t'(sel_kind);
  assign go_stop = stop;
  assign go_sel  = sel_valid && !stop;
  assign go_wr   = wr_valid && !stop && !sel_valid;
  assign go_rd   = rd_req && !stop && !sel_valid && !wr_valid;

  assign prot_on   = soft_q | perm_q;
  assign lower_hit = ~addr_q[ADDR_W-1];

  always_comb begin
    case (pkind_q)
      K_SETP:  prot_ok = !prot_on;
      K_CLRP:  prot_ok = !perm_q;
      K_PERM:  prot_ok = !perm_q;
      default: prot_ok = 1'b0;
    endcase
  end

  assign buf_we  = go_wr && (tx_q == TX_WDATA) && !(lower_hit && prot_on);
  assign buf_clr = go_stop || go_sel;
  assign commit  = go_stop && (buf_mask != '0);
  assign start   = go_stop && ((buf_mask != '0) || pend_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q      <= TX_NONE;
      pkind_q   <= K_MEM;
      addr_q    <= '0;
      soft_q    <= 1'b0;
      perm_q    <= 1'b0;
      pend_q    <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_ack   <= 1'b0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
    end else begin
      rsp_valid <= 1'b0;
      rd_valid  <= 1'b0;
      if (go_stop) begin
        tx_q   <= TX_NONE;
        pend_q <= 1'b0;
        if (pend_q) begin
          case (pkind_q)
            K_SETP:  soft_q <= 1'b1;
            K_CLRP:  soft_q <= 1'b0;
            K_PERM:  perm_q <= 1'b1;
            default: ;
          endcase
        end
      end else if (go_sel) begin
        rsp_valid <= 1'b1;
        pend_q    <= 1'b0;
        if (busy) begin
          rsp_ack <= 1'b0;
          tx_q    <= TX_NONE;
        end else if (sel_rd) begin
          case (sel_k)
            K_MEM: begin
              rsp_ack <= 1'b1;
              tx_q    <= TX_READ;
            end
            K_PERM: begin
              rsp_ack <= !perm_q;
              tx_q    <= TX_NONE;
            end
            default: begin
              rsp_ack <= !soft_q;
              tx_q    <= TX_NONE;
            end
          endcase
        end else begin
          rsp_ack <= 1'b1;
          pkind_q <= sel_k;
          tx_q    <= (sel_k == K_MEM) ? TX_WADDR : TX_PADDR;
        end
      end else if (go_wr) begin
        rsp_valid <= 1'b1;
        case (tx_q)
          TX_WADDR: begin
            rsp_ack <= 1'b1;
            addr_q  <= wr_byte;
            tx_q    <= TX_WDATA;
          end
          TX_WDATA: begin
            if (lower_hit && prot_on) begin
              rsp_ack <= 1'b0;
              tx_q    <= TX_DEAD;
            end else begin
              rsp_ack <= 1'b1;
              addr_q  <= {addr_q[ADDR_W-1:COL_W], addr_q[COL_W-1:0] + 1'b1};
            end
          end
          TX_PADDR: begin
            rsp_ack <= 1'b1;
            tx_q    <= TX_PDATA;
          end
          TX_PDATA: begin
            rsp_ack <= prot_ok;
            pend_q  <= prot_ok;
            tx_q    <= TX_DEAD;
          end
          default: rsp_ack <= 1'b0;
        endcase
      end else if (go_rd && tx_q == TX_READ) begin
        rd_valid <= 1'b1;
        rd_data  <= arr_rd;
        addr_q   <= addr_q + 1'b1;
      end
    end
  end

  wpc_page_buf #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(buf_clr), .we(buf_we),
    .col(addr_q[COL_W-1:0]), .din(wr_byte),
    .mask(buf_mask), .data_flat(buf_data)
  );

  wpc_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)) u_arr (
    .clk(clk), .rst_n(rst_n), .commit(commit),
    .page(addr_q[ADDR_W-1:COL_W]), .mask(buf_mask), .data_flat(buf_data),
    .rd_addr(addr_q), .rd_data(arr_rd)
  );

  wpc_cycle_timer #(.CYCLES(WRITE_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy)
  );

  // R4
  busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && !stop && busy) |=> (rsp_valid && !rsp_ack));

  // R8
  perm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    perm_q |=> perm_q);

  // R6
  lower_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !addr_q[ADDR_W-1]) |-> !prot_on);

  // R11
  rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_req));

  // R11
  rsp_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(sel_valid) || $past(wr_valid)));

endmodule

// File: tb/tb_wpc_eeprom_ctrl.sv
module tb_wpc_eeprom_ctrl;
  localparam int WC = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_valid = 0, sel_rd = 0, wr_valid = 0, rd_req = 0, stop = 0;
  logic [1:0] sel_kind = 0;
  logic [7:0] wr_byte = 0;
  logic rsp_valid, rsp_ack, rd_valid, busy;
  logic [7:0] rd_data;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  wpc_eeprom_ctrl #(.WRITE_CYCLES(WC)) dut (
    .clk(clk), .rst_n(rst_n), .sel_valid(sel_valid), .sel_kind(sel_kind),
    .sel_rd(sel_rd), .wr_valid(wr_valid), .wr_byte(wr_byte), .rd_req(rd_req),
    .stop(stop), .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .rd_valid(rd_valid),
    .rd_data(rd_data), .busy(busy)
  );

  // op: 0 select (a = kind*2 + rd), 1 write byte, 2 read byte, 3 stop (exp = busy)
  function automatic logic [23:0] v(input int op, input int a, input int chk,
                                    input int ex, input int rq);
    return {3'(op), 8'(a), 1'(chk), 8'(ex), 4'(rq)};
  endfunction

  localparam int NV = 63;
  localparam logic [23:0] VEC [NV] = '{
    // R2 single byte write
    v(0,8'h00,1,1,2), v(1,8'h85,1,1,2), v(1,8'h3C,1,1,2), v(3,0,1,1,2),
    // R3 page write wrapping 9E,9F,90
    v(0,8'h00,1,1,3), v(1,8'h9E,1,1,3), v(1,8'h11,1,1,3), v(1,8'h22,1,1,3),
    v(1,8'h33,1,1,3), v(3,0,1,1,3),
    // R5 random read continuing past the page edge
    v(0,8'h00,1,1,5), v(1,8'h9E,1,1,5), v(0,8'h01,1,1,5), v(2,0,1,8'h11,5),
    v(2,0,1,8'h22,5), v(2,0,1,8'hFF,5), v(3,0,1,0,5),
    // R3 wrapped byte at 90
    v(0,8'h00,1,1,3), v(1,8'h90,1,1,3), v(0,8'h01,1,1,3), v(2,0,1,8'h33,3), v(3,0,1,0,3),
    // R5 rollover FF -> 00
    v(0,8'h00,1,1,5), v(1,8'h00,1,1,5), v(1,8'h5A,1,1,5), v(3,0,1,1,5),
    v(0,8'h00,1,1,5), v(1,8'hFF,1,1,5), v(0,8'h01,1,1,5), v(2,0,1,8'hFF,5),
    v(2,0,1,8'h5A,5), v(3,0,1,0,5),
    // R6 set-protect
    v(0,8'h02,1,1,6), v(1,8'h00,1,1,6), v(1,8'h00,1,1,6), v(3,0,1,1,6),
    // R9 query reversible flag: set -> nack
    v(0,8'h03,1,0,9),
    // R6 lower write refused, upper accepted
    v(0,8'h00,1,1,6), v(1,8'h10,1,1,6), v(1,8'h77,1,0,6), v(3,0,1,0,6),
    v(0,8'h00,1,1,6), v(1,8'h85,1,1,6), v(1,8'h44,1,1,6), v(3,0,1,1,6),
    // R10 read lower half while protected
    v(0,8'h00,1,1,10), v(1,8'h00,1,1,10), v(0,8'h01,1,1,10), v(2,0,1,8'h5A,10), v(3,0,1,0,10),
    // R6 redundant set refused
    v(0,8'h02,1,1,6), v(1,8'h00,1,1,6), v(1,8'h00,1,0,6), v(3,0,1,0,6),
    // R7 clear-protect, then query and lower write
    v(0,8'h04,1,1,7), v(1,8'h00,1,1,7), v(1,8'h00,1,1,7), v(3,0,1,1,7),
    v(0,8'h03,1,1,7),
    v(0,8'h00,1,1,7), v(1,8'h10,1,1,7), v(1,8'h77,1,1,7), v(3,0,1,1,7)
  };

  task automatic check(input bit ok, input string rq, input int act, input int ex);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, ex);
    end
  endtask

  task automatic do_sel(input logic [1:0] k, input logic r, output logic ack);
    @(negedge clk); sel_valid = 1; sel_kind = k; sel_rd = r;
    @(negedge clk); sel_valid = 0;
    check(rsp_valid, "R11 select response", rsp_valid, 1);
    ack = rsp_ack;
  endtask

  task automatic do_wr(input logic [7:0] b, output logic ack);
    @(negedge clk); wr_valid = 1; wr_byte = b;
    @(negedge clk); wr_valid = 0;
    check(rsp_valid, "R11 byte response", rsp_valid, 1);
    ack = rsp_ack;
  endtask

  task automatic do_rd(output logic [7:0] d);
    @(negedge clk); rd_req = 1;
    @(negedge clk); rd_req = 0;
    check(rd_valid, "R11 read response", rd_valid, 1);
    d = rd_data;
  endtask

  task automatic do_stop(output logic b);
    @(negedge clk); stop = 1;
    @(negedge clk); stop = 0;
    b = busy;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic a;
    logic b;
    logic [7:0] d;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(!busy && !rsp_valid && !rd_valid, "R1 idle outputs", {busy, rsp_valid, rd_valid}, 0);
    do_sel(2'b00, 1'b1, a);
    check(a, "R1 read select", a, 1);
    do_rd(d);
    check(d == 8'hFF, "R1 erased byte at 00", d, 8'hFF);
    do_rd(d);
    check(d == 8'hFF, "R1 erased byte at 01", d, 8'hFF);
    do_sel(2'b11, 1'b1, a);
    check(a, "R1 permanent lock off", a, 1);
    do_stop(b);

    for (int i = 0; i < NV; i++) begin
      logic [2:0] op;
      logic [7:0] arg;
      logic       chk;
      logic [7:0] ex;
      logic [3:0] rq;
      {op, arg, chk, ex, rq} = VEC[i];
      case (op)
        3'd0: begin
          do_sel(arg[2:1], arg[0], a);
          if (chk) check(a == ex[0], $sformatf("R%0d select ack v%0d", rq, i), a, ex);
        end
        3'd1: begin
          do_wr(arg, a);
          if (chk) check(a == ex[0], $sformatf("R%0d byte ack v%0d", rq, i), a, ex);
        end
        3'd2: begin
          do_rd(d);
          if (chk) check(d == ex, $sformatf("R%0d read data v%0d", rq, i), d, ex);
        end
        default: begin
          do_stop(b);
          if (chk) check(b == ex[0], $sformatf("R%0d busy after stop v%0d", rq, i), b, ex);
          wait_idle(n);
        end
      endcase
    end

    // R2 busy length
    do_sel(2'b00, 1'b0, a); do_wr(8'hB0, a); do_wr(8'h5C, a);
    do_stop(b);
    wait_idle(n);
    check(n == WC, "R2 busy cycle count", n, WC);

    // R8 permanent lock
    do_sel(2'b11, 1'b0, a); do_wr(8'h00, a); do_wr(8'h00, a);
    check(a, "R8 permanent data ack", a, 1);
    do_stop(b);
    check(b, "R8 permanent starts cycle", b, 1);
    wait_idle(n);
    do_sel(2'b11, 1'b1, a);
    check(!a, "R9 permanent query nack", a, 0);
    do_sel(2'b10, 1'b0, a); do_wr(8'h00, a); do_wr(8'h00, a);
    check(!a, "R8 clear after lock nack", a, 0);
    do_stop(b);
    check(!b, "R8 clear after lock no cycle", b, 0);
    do_sel(2'b00, 1'b0, a); do_wr(8'h20, a); do_wr(8'h99, a);
    check(!a, "R8 lower write nack", a, 0);
    do_stop(b);
    check(!b, "R8 lower write no cycle", b, 0);
    do_sel(2'b00, 1'b0, a); do_wr(8'h10, a); do_sel(2'b00, 1'b1, a);
    do_rd(d);
    check(d == 8'h77, "R10 lower data under lock", d, 8'h77);
    do_rd(d);
    do_stop(b);
    do_sel(2'b00, 1'b0, a); do_wr(8'h20, a); do_sel(2'b00, 1'b1, a);
    do_rd(d);
    check(d == 8'hFF, "R8 refused byte not stored", d, 8'hFF);
    do_stop(b);

    // R3 seventeen bytes into page C0, R4 polling while busy
    do_sel(2'b00, 1'b0, a); do_wr(8'hC0, a);
    for (int k = 1; k <= 17; k++) do_wr(8'(k), a);
    do_stop(b);
    do_sel(2'b00, 1'b0, a);
    check(!a, "R4 memory select while busy", a, 0);
    do_sel(2'b01, 1'b1, a);
    check(!a, "R4 query while busy", a, 0);
    wait_idle(n);
    do_sel(2'b00, 1'b0, a);
    check(a, "R4 select after cycle", a, 1);
    do_wr(8'hC0, a); do_sel(2'b00, 1'b1, a);
    do_rd(d);
    check(d == 8'h11, "R3 17th byte replaced C0", d, 8'h11);
    do_rd(d);
    check(d == 8'h02, "R3 C1 holds second byte", d, 8'h02);
    do_stop(b);

    // R11 read request outside read transaction
    @(negedge clk); rd_req = 1;
    @(negedge clk); rd_req = 0;
    check(!rd_valid, "R11 stray read ignored", rd_valid, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule